// File: doc/BRIEF.md
# Saturating Doubling Multiply-Long Unit

This block executes a small scalar group of signed, saturating, doubling, widening multiplies. A 32-bit instruction word is presented together with operand values already fetched from the register file: the two source registers, of which only the lowest element is used, and the prior contents of the destination register. The unit decodes the word and computes twice the signed product of the two source elements. Depending on the opcode it returns that doubled product, adds it to the prior destination value, or subtracts it from that value. Every addition clamps to the signed range of the double-width result.

Two element widths are supported. 16-bit sources produce a 32-bit result, which is zero-extended into the 64-bit destination. 32-bit sources produce a full 64-bit result. Saturation can happen at two points: when the product is doubled, and again when the accumulate is applied. For the subtract form, the already-clamped doubled product is negated in two's complement before the accumulate. The result and flags are registered one clock after an input strobe. Any clamp sets a sticky saturation flag, which stays set until it is explicitly cleared.

Top module: `dml_unit`

## Requirements
- R1: When instruction bit 29 is 1, the operation is undefined: `undef` is raised and no write happens.
- R2: The opcode sits in instruction bits 15:12. The value 0xD means multiply only, 0x9 means multiply-accumulate and 0xB means multiply-subtract. Every other opcode is undefined.
- R3: The size field sits in bits 23:22. The value 1 selects signed 16-bit elements, taken from bits 15:0 of each source. The value 2 selects signed 32-bit elements, taken from bits 31:0. The values 0 and 3 are undefined.
- R4: The full signed product is doubled with saturation. If the doubled value leaves the signed 32-bit range (16-bit elements) or the signed 64-bit range (32-bit elements), it is clamped to the nearest limit.
- R5: Multiply-accumulate adds the clamped doubled product to the prior destination value with signed saturation. That prior value is its low 32 bits for 16-bit elements and all 64 bits for 32-bit elements. Upper bits that are not used have no effect.
- R6: Multiply-subtract negates the clamped doubled product in two's complement and then adds it to the prior value with saturation. Negating the most negative value wraps to itself without setting the flag.
- R7: For 16-bit elements, `result[63:32]` is zero. The 32-bit result occupies bits 31:0.
- R8: `out_valid` follows `in_valid` by exactly one clock. While `out_valid` is 1, exactly one of `wr_en` and `undef` is 1. When `out_valid` is 0, both are 0. When `undef` is 1, `result` is zero.
- R9: `sat_flag` is set in the clock after any valid operation clamps at either saturation step. It holds until `sat_clear` is sampled high, which clears it. A clamp in the same cycle as the clear leaves the flag set.
- R10: After a synchronous active-low reset, `out_valid`, `wr_en`, `undef`, `dst_idx`, `result` and `sat_flag` are all zero.
- R11: While `out_valid` is 1, `dst_idx` carries instruction bits 4:0 of the strobed word. Otherwise it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| src_n | input | 64 | First source register contents |
| src_m | input | 64 | Second source register contents |
| dst_prior | input | 64 | Prior destination register contents |
| sat_clear | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Registered result is present |
| wr_en | output | 1 | Destination should be written with `result` |
| undef | output | 1 | The strobed instruction is undefined |
| dst_idx | output | 5 | Destination register index |
| result | output | 64 | Value to write to the destination |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The bench drives the most-negative times most-negative product at both widths. A unit that widened without saturating the doubling would return the most negative value instead of the most positive one and would leave the flag clear. Accumulates that overflow in both directions catch a missing or one-sided second clamp. Multiply-subtract cases catch a design that negates after the accumulate, or that uses the unclamped product. Garbage in the unused upper bits of the sources and the prior destination exposes wrong element or accumulator slicing and a missing zero-extension. Every undefined size, the unsigned bit and stray opcodes check that no write leaks out. A clear issued in the same cycle as a new clamp shows whether set takes priority over clear.

// File: rtl/dml_pkg.sv
// Package: shared field positions, operation codes and the decoded-instruction
// record for the saturating doubling multiply-long unit.
// Assumes a 32-bit instruction word whose field layout is fixed below.
package dml_pkg;

    localparam int INSTR_W    = 32;
    localparam int IDX_W      = 5;
    localparam int UBIT_POS   = 29;
    localparam int SIZE_LSB   = 22;
    localparam int OPC_LSB    = 12;
    localparam int RD_LSB     = 0;

    localparam logic [3:0] OPC_MUL = 4'hD;
    localparam logic [3:0] OPC_MLA = 4'h9;
    localparam logic [3:0] OPC_MLS = 4'hB;

    typedef enum logic [1:0] {
        OP_MUL = 2'd0,
        OP_MLA = 2'd1,
        OP_MLS = 2'd2
    } dml_op_e;

    typedef struct packed {
        logic             legal;
        logic [1:0]       lane;   // size field minus one
        dml_op_e          op;
        logic [IDX_W-1:0] rd;
    } dml_dec_t;

endpackage

// File: rtl/dml_decode.sv
// Decoder: classifies an instruction word as one of the three operations or
// as undefined, and selects the element-width lane.
// Assumes N_SIZES lanes, numbered from size code 1 upward.
module dml_decode
    import dml_pkg::*;
#(
    parameter int N_SIZES = 2
) (
    input  logic [INSTR_W-1:0] instr,
    output dml_dec_t           dec
);

    logic       ubit;
    logic [1:0] size_f;
    logic [3:0] opc_f;
    logic       opc_ok;
    logic       size_ok;

    // Purpose: pull the fields out of the word and judge legality.
    always_comb begin
        ubit    = instr[UBIT_POS];
        size_f  = instr[SIZE_LSB +: 2];
        opc_f   = instr[OPC_LSB +: 4];
        opc_ok  = (opc_f == OPC_MUL) || (opc_f == OPC_MLA) || (opc_f == OPC_MLS);
        size_ok = (size_f != 2'd0) && (int'(size_f) <= N_SIZES);

        dec.legal = !ubit && opc_ok && size_ok;
        dec.lane  = size_f - 2'd1;
        dec.rd    = instr[RD_LSB +: IDX_W];
        unique case (opc_f)
            OPC_MLA: dec.op = OP_MLA;
            OPC_MLS: dec.op = OP_MLS;
            default: dec.op = OP_MUL;
        endcase
    end

endmodule

// File: rtl/dml_lane.sv
// Lane: one element width. Forms the signed product, doubles it with
// saturation, optionally negates it (wrapping) and accumulates with saturation.
// Assumes EW-bit signed sources and a 2*EW-bit accumulator; purely combinational.
module dml_lane
    import dml_pkg::*;
#(
    parameter int EW = 16
) (
    input  logic [EW-1:0]   a,
    input  logic [EW-1:0]   b,
    input  logic [2*EW-1:0] acc,
    input  dml_op_e         op,
    output logic [2*EW-1:0] res,
    output logic            sat
);

    localparam int RW = 2 * EW;
    localparam logic [RW-1:0] RMAX = {1'b0, {(RW-1){1'b1}}};
    localparam logic [RW-1:0] RMIN = {1'b1, {(RW-1){1'b0}}};
    localparam logic [EW-1:0] EMIN = {1'b1, {(EW-1){1'b0}}};

    // Saturating signed add; returns {overflow, clamped sum}.
    function automatic logic [RW:0] sat_add(input logic [RW-1:0] x, input logic [RW-1:0] y);
        logic [RW:0] s;
        s = {x[RW-1], x} + {y[RW-1], y};
        if (s[RW] != s[RW-1])
            return {1'b1, (s[RW] ? RMIN : RMAX)};
        return {1'b0, s[RW-1:0]};
    endfunction

    logic signed [RW-1:0] ax, bx;
    logic [RW-1:0]        prod;
    logic [RW:0]          dbl_pack;
    logic [RW-1:0]        dbl;
    logic [RW-1:0]        addend;
    logic [RW:0]          acc_pack;

    // Purpose: widen, multiply and double with the first clamp.
    always_comb begin
        ax       = {{EW{a[EW-1]}}, a};
        bx       = {{EW{b[EW-1]}}, b};
        prod     = ax * bx;
        dbl_pack = sat_add(prod, prod);
        dbl      = dbl_pack[RW-1:0];
    end

    // Purpose: negate for subtract (wrapping), then apply the second clamp.
    always_comb begin
        addend   = (op == OP_MLS) ? (~dbl + 1'b1) : dbl;
        acc_pack = sat_add(addend, acc);
        if (op == OP_MUL) begin
            res = dbl;
            sat = dbl_pack[RW];
        end else begin
            res = acc_pack[RW-1:0];
            sat = dbl_pack[RW] | acc_pack[RW];
        end
    end

    // The doubling can only clamp for most-negative times most-negative.
    always_comb begin
        p_dbl_clamp_r4: assert (dbl_pack[RW] == ((a == EMIN) && (b == EMIN)))
            else $error("doubling clamp mismatch");
    end

endmodule

// File: rtl/dml_unit.sv
// Top: saturating doubling multiply-long unit. Decodes the word, runs one
// lane per element width, registers the selected result and flags one clock
// after in_valid, and keeps a sticky saturation flag.
// Assumes operands are presented with in_valid; 2*widest element <= DATA_W.
module dml_unit
    import dml_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int BASE_EW  = 16,
    parameter int N_SIZES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [31:0]        instr,
    input  logic [DATA_W-1:0]  src_n,
    input  logic [DATA_W-1:0]  src_m,
    input  logic [DATA_W-1:0]  dst_prior,
    input  logic               sat_clear,
    output logic               out_valid,
    output logic               wr_en,
    output logic               undef,
    output logic [4:0]         dst_idx,
    output logic [DATA_W-1:0]  result,
    output logic               sat_flag
);

    localparam int NARROW_RW = 2 * BASE_EW;

    dml_dec_t          dec;
    logic [DATA_W-1:0] lane_res [N_SIZES];
    logic              lane_sat [N_SIZES];
    logic [DATA_W-1:0] sel_res;
    logic              sel_sat;
    logic              do_write;
    logic              half_q;

    dml_decode #(.N_SIZES(N_SIZES)) u_dec (
        .instr (instr),
        .dec   (dec)
    );

    for (genvar g = 0; g < N_SIZES; g++) begin : g_lane
        localparam int EW = BASE_EW << g;
        logic [2*EW-1:0] r;
        logic            s;
        dml_lane #(.EW(EW)) u_lane (
            .a   (src_n[EW-1:0]),
            .b   (src_m[EW-1:0]),
            .acc (dst_prior[2*EW-1:0]),
            .op  (dec.op),
            .res (r),
            .sat (s)
        );
        assign lane_res[g] = DATA_W'(r);
        assign lane_sat[g] = s;
    end

    // Purpose: pick the lane named by the size field.
    always_comb begin
        sel_res = '0;
        sel_sat = 1'b0;
        for (int i = 0; i < N_SIZES; i++) begin
            if (int'(dec.lane) == i) begin
                sel_res = lane_res[i];
                sel_sat = lane_sat[i];
            end
        end
        do_write = in_valid && dec.legal;
    end

    // Purpose: register result, strobes, index and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            undef     <= 1'b0;
            dst_idx   <= '0;
            result    <= '0;
            sat_flag  <= 1'b0;
            half_q    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= do_write;
            undef     <= in_valid && !dec.legal;
            dst_idx   <= in_valid ? dec.rd : '0;
            result    <= do_write ? sel_res : '0;
            half_q    <= (dec.lane == 2'd0);
            sat_flag  <= (sat_clear ? 1'b0 : sat_flag) | (do_write && sel_sat);
        end
    end

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (wr_en ^ undef));
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!wr_en && !undef));
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_undef_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (result == '0));
    p_ubit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[UBIT_POS]) |=> undef);
    p_zext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && half_q) |-> (result[DATA_W-1:NARROW_RW] == '0));
    p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sat_clear) |=> sat_flag);

endmodule

// File: tb/dml_unit_test.sv
`timescale 1ns/1ps
module dml_unit_test;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] src_n = '0, src_m = '0, dst_prior = '0;
    logic        sat_clear = 1'b0;
    logic        out_valid, wr_en, undef, sat_flag;
    logic [4:0]  dst_idx;
    logic [63:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // expected outputs for the next compare, plus the tag of the stimulus
    logic        e_valid = 0, e_wr = 0, e_undef = 0, e_sticky = 0;
    logic [4:0]  e_idx = '0;
    logic [63:0] e_res = '0;
    string       e_tag = "R10";
    string       tag_q[$];

    always #(HALF) clk = ~clk;

    dml_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_n(src_n), .src_m(src_m), .dst_prior(dst_prior), .sat_clear(sat_clear),
        .out_valid(out_valid), .wr_en(wr_en), .undef(undef), .dst_idx(dst_idx),
        .result(result), .sat_flag(sat_flag)
    );

    function automatic logic [31:0] mk(input bit u, input logic [1:0] sz,
                                       input logic [3:0] op, input logic [4:0] rd);
        logic [31:0] w;
        w = 32'h5E20_0000;            // arbitrary filler in unused bits
        w[29] = u; w[23:22] = sz; w[15:12] = op; w[4:0] = rd;
        w[20:16] = 5'd7; w[9:5] = 5'd3;
        return w;
    endfunction

    function automatic logic signed [127:0] clampw(input logic signed [127:0] v,
                                                   input int w, inout bit s);
        logic signed [127:0] hi, lo;
        hi = (128'sd1 <<< (w - 1)) - 128'sd1;
        lo = -(128'sd1 <<< (w - 1));
        if (v > hi) begin s = 1; return hi; end
        if (v < lo) begin s = 1; return lo; end
        return v;
    endfunction

    // Behavioural reference for one operation.
    task automatic model(input logic [31:0] w, input logic [63:0] a, b, d,
                         output bit und, output logic [63:0] r, output bit s);
        logic [1:0] sz; logic [3:0] op; int ew;
        logic signed [127:0] pa, pb, acc, v, minv;
        sz = w[23:22]; op = w[15:12];
        s = 0; r = '0;
        und = w[29] || !(op == 4'hD || op == 4'h9 || op == 4'hB) || sz == 0 || sz == 3;
        if (und) return;
        ew = (sz == 1) ? 16 : 32;
        if (ew == 16) begin
            pa = $signed(a[15:0]); pb = $signed(b[15:0]); acc = $signed(d[31:0]);
        end else begin
            pa = $signed(a[31:0]); pb = $signed(b[31:0]); acc = $signed(d);
        end
        v = clampw(pa * pb * 2, 2 * ew, s);
        minv = -(128'sd1 <<< (2 * ew - 1));
        if (op == 4'hB) v = (v == minv) ? v : -v;
        if (op != 4'hD) v = clampw(v + acc, 2 * ew, s);
        r = (ew == 16) ? {32'h0, v[31:0]} : v[63:0];
    endtask

    task automatic chk(input string what, input logic [63:0] act, exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", e_tag, what, act, exp);
        end
    endtask

    // Compare all outputs at the falling edge, then apply the next stimulus.
    task automatic step(input bit v, input logic [31:0] w, input logic [63:0] a, b, d,
                        input bit clr, input string tag);
        bit und, s; logic [63:0] r;
        @(negedge clk);
        chk("out_valid", 64'(out_valid), 64'(e_valid));
        chk("wr_en", 64'(wr_en), 64'(e_wr));
        chk("undef", 64'(undef), 64'(e_undef));
        chk("dst_idx", 64'(dst_idx), 64'(e_idx));
        chk("result", result, e_res);
        chk("sat_flag (R9)", 64'(sat_flag), 64'(e_sticky));
        in_valid = v; instr = w; src_n = a; src_m = b; dst_prior = d; sat_clear = clr;
        model(w, a, b, d, und, r, s);
        tag_q.push_back(tag);
        e_tag    = tag_q.pop_front();
        e_valid  = v;
        e_wr     = v && !und;
        e_undef  = v && und;
        e_idx    = v ? w[4:0] : '0;
        e_res    = (v && !und) ? r : '0;
        e_sticky = (clr ? 1'b0 : e_sticky) | (v && !und && s);
    endtask

    initial begin
        #(HALF * 2 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R10: outputs zero during reset
        e_tag = "R10";
        step(0, '0, '0, '0, '0, 0, "R10");
        @(negedge clk); rst_n = 1'b1;
        step(0, '0, '0, '0, '0, 0, "R8 idle");
        // R3/R11: 16-bit multiply, garbage upper bits
        step(1, mk(0, 2'd1, 4'hD, 5'd9), 64'hDEAD_BEEF_1234_0003, 64'hFFFF_0000_5555_FFFC,
             64'hFFFF_FFFF_FFFF_FFFF, 0, "R3 R11 mul16");
        // R4: 16-bit doubling clamp
        step(1, mk(0, 2'd1, 4'hD, 5'd1), 64'h8000, 64'h1111_8000, '0, 0, "R4 R9 clamp16");
        step(0, '0, '0, '0, '0, 1, "R9 clear");
        // R5: accumulate overflow on the low 32 bits, upper half ignored
        step(1, mk(0, 2'd1, 4'h9, 5'd2), 64'h4000, 64'h4000, 64'hAAAA_AAAA_7FFF_0000, 0, "R5 mla16");
        step(1, mk(0, 2'd1, 4'h9, 5'd3), 64'h0010, 64'h0020, 64'h1234_5678_0000_0100, 1, "R5 R9 mla16 clr");
        // R6/R7: subtract gives negative 32-bit result, zero-extended
        step(1, mk(0, 2'd1, 4'hB, 5'd4), 64'h0100, 64'h0100, 64'hFFFF_FFFF_0000_0005, 0, "R6 R7 mls16");
        step(1, mk(0, 2'd1, 4'hB, 5'd5), 64'h8000, 64'h8000, 64'h8000_0000, 0, "R6 mls16 sat");
        // R4: 32-bit doubling clamp
        step(1, mk(0, 2'd2, 4'hD, 5'd6), 64'h1_8000_0000, 64'h8000_0000, '0, 1, "R4 clamp32");
        step(1, mk(0, 2'd2, 4'h9, 5'd7), 64'hC000_0000, 64'h7FFF_FFFF, 64'h8000_0000_0000_0001, 1, "R5 mla32 neg");
        step(1, mk(0, 2'd2, 4'hB, 5'd8), 64'h10000, 64'h10000, 64'h8000_0000_0000_0000, 1, "R6 mls32");
        step(1, mk(0, 2'd2, 4'h9, 5'd10), 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF, 64'd40, 1, "R5 mla32");
        // R1/R2/R3: undefined forms
        step(1, mk(1, 2'd1, 4'hD, 5'd11), 64'h3, 64'h3, '0, 0, "R1 ubit");
        step(1, mk(0, 2'd1, 4'h1, 5'd12), 64'h3, 64'h3, '0, 0, "R2 bad opc");
        step(1, mk(0, 2'd1, 4'hE, 5'd12), 64'h3, 64'h3, '0, 0, "R2 bad opc");
        step(1, mk(0, 2'd0, 4'h9, 5'd13), 64'h3, 64'h3, '0, 0, "R3 size0");
        step(1, mk(0, 2'd3, 4'hB, 5'd14), 64'h3, 64'h3, '0, 0, "R3 size3");
        step(0, '0, '0, '0, '0, 0, "R8 idle");
        // random mix of valid and invalid words
        for (int i = 0; i < 400; i++) begin
            logic [3:0] op; logic [1:0] sz; logic [63:0] a, b, d;
            case ($urandom_range(0, 3))
                0: op = 4'hD; 1: op = 4'h9; 2: op = 4'hB; default: op = 4'($urandom);
            endcase
            sz = ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'($urandom_range(1, 2));
            a = {$urandom, $urandom}; b = {$urandom, $urandom}; d = {$urandom, $urandom};
            if ($urandom_range(0, 4) == 0) begin a[31:0] = 32'h8000_0000; a[15:0] = 16'h8000; end
            step($urandom_range(0, 5) != 0, mk($urandom_range(0, 9) == 0, sz, op, 5'($urandom)),
                 a, b, d, $urandom_range(0, 7) == 0, "R4 R5 R6 R8 random");
        end
        step(0, '0, '0, '0, '0, 0, "R8 idle");
        step(0, '0, '0, '0, '0, 0, "R8 idle");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule